// File: doc/BRIEF.md
# Realm Permission Checker

This block answers one question for an administrator whose identity has already been proven elsewhere: may this caller act in the requested access realm? It keeps two small tables. One table is keyed by a user identifier and is used for password-based administrators. The other table is keyed by a group identifier and is used for ticket-based administrators. Every valid entry carries a realm bitmap. In that bitmap, bit n set to 1 allows realm n and bit n cleared denies it. One hard-wired security administrator key has every defined realm without needing any table entry.

Queries arrive on a valid/ready stream. A user query is a single beat that carries the user key and the realm number. A group query streams one group identifier per beat. The final beat is marked and carries the realm number. The rights of a group query are the union of the bitmaps of every matching group entry. The allow/deny answer is registered and is strobed exactly one cycle after the final beat. The answer port has no back-pressure, so `q_ready` is held high. A configuration stream writes or clears single slots. A configuration write takes effect only when the caller holds the security-administration realm. `cfg_ready` drops while any query beat is offered or a group stream is open. This keeps the tables stable for the whole of a query.

Top module: `realm_permission_checker`

## Requirements
- R1: After reset every slot of both tables is invalid, `resp_valid` and `resp_allow` are low, and `cfg_ready` is high.
- R2: A user query (`q_group`=0 on a beat that opens a query) allows realm n when some valid user slot holds the key and has bitmap bit n set. When several slots hold the same key, their bitmaps are ORed.
- R3: A query whose key matches no valid slot of the table it addresses is denied.
- R4: A user query with key 8'hFF (the security administrator) is allowed for every realm 0..11, whatever the tables hold.
- R5: Realm numbers 12..15 are denied for every caller, the security administrator included.
- R6: A group query (`q_group`=1 on the opening beat) takes one group identifier per accepted beat until a beat with `q_last`=1. Idle cycles between beats are allowed. The allowed realms are the OR of the bitmaps of all valid group slots matching any streamed identifier. The realm is taken from the final beat only.
- R7: `resp_valid` pulses high for one cycle, in the cycle after the final beat is accepted, and at no other time. `resp_allow` is low whenever `resp_valid` is low.
- R8: A configuration beat (`cfg_valid` and `cfg_ready`) takes effect only if `cfg_caller` is 8'hFF or matches a valid user slot whose bitmap has bit 11 set. Any other configuration beat leaves both tables unchanged.
- R9: An authorised beat with `cfg_clear`=1 invalidates slot `cfg_index` of the table selected by `cfg_group` (0 user, 1 group). With `cfg_clear`=0 it stores `cfg_key` and `cfg_bits` there and marks the slot valid. The change affects queries whose first beat comes in a later cycle.
- R10: `q_ready` is always high. `cfg_ready` is low in any cycle where `q_valid` is high or a group stream has been opened but not closed.
- R11: A user query is always a single beat and completes whatever the value of `q_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_valid | input | 1 | Query beat offered |
| q_ready | output | 1 | Query beat accepted (always high) |
| q_group | input | 1 | On an opening beat: 0 user query, 1 group query |
| q_last | input | 1 | Final beat of a group query |
| q_key | input | 8 | User key or group identifier of this beat |
| q_realm | input | 4 | Requested realm number (used on the final beat) |
| resp_valid | output | 1 | One-cycle answer strobe |
| resp_allow | output | 1 | 1 allow, 0 deny; valid with `resp_valid` |
| cfg_valid | input | 1 | Configuration beat offered |
| cfg_ready | output | 1 | Configuration beat may be accepted |
| cfg_caller | input | 8 | User key of the administrator issuing the beat |
| cfg_group | input | 1 | Target table: 0 user, 1 group |
| cfg_clear | input | 1 | 1 invalidates the slot, 0 writes it |
| cfg_index | input | 3 | Slot number in the target table |
| cfg_key | input | 8 | Key stored in the slot |
| cfg_bits | input | 12 | Realm bitmap stored in the slot |

## Verification
A corrupted slot, a stale valid flag or a wrong union shows up as a wrong `resp_allow` on the strobe one cycle after the final beat. A full sweep of keys and realms therefore exposes the fault at the first query that touches the faulty slot. A group stream that fails to close shows at once as `cfg_ready` stuck low and as missing or extra strobes. An authorisation fault in configuration shows on the first later query to the slot that should, or should not, have been written.

// File: rtl/realm_chk_pkg.sv
package realm_chk_pkg;
  typedef enum logic {
    TBL_USER  = 1'b0,
    TBL_GROUP = 1'b1
  } tbl_sel_e;
endpackage

// File: rtl/realm_table.sv
// One table of keyed realm bitmaps with NLK independent combinational lookups.
module realm_table #(
  parameter int N        = 8,
  parameter int KEY_W    = 8,
  parameter int N_REALMS = 12,
  parameter int IDX_W    = 3,
  parameter int NLK      = 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic                             wr_clear,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [KEY_W-1:0]                 wr_key,
  input  logic [N_REALMS-1:0]              wr_bits,
  input  logic [NLK-1:0][KEY_W-1:0]        lk_key,
  output logic [NLK-1:0][N_REALMS-1:0]     lk_bits
);
  logic [N-1:0]               slot_vld;
  logic [N-1:0][KEY_W-1:0]    slot_key;
  logic [N-1:0][N_REALMS-1:0] slot_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_vld  <= '0;
      slot_key  <= '0;
      slot_bits <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < N; i++) begin
        if (wr_idx == IDX_W'(i)) begin
          if (wr_clear) begin
            slot_vld[i] <= 1'b0;
          end else begin
            slot_vld[i]  <= 1'b1;
            slot_key[i]  <= wr_key;
            slot_bits[i] <= wr_bits;
          end
        end
      end
    end
  end

  for (genvar l = 0; l < NLK; l++) begin : g_lookup
    always_comb begin
      lk_bits[l] = '0;
      for (int i = 0; i < N; i++) begin
        if (slot_vld[i] && (slot_key[i] == lk_key[l])) lk_bits[l] = lk_bits[l] | slot_bits[i];
      end
    end
  end
endmodule

// File: rtl/realm_accum.sv
// Collects the rights of a query across its beats and registers the decision.
module realm_accum #(
  parameter int N_REALMS = 12,
  parameter int REALM_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                beat,
  input  logic                beat_group,
  input  logic                beat_last,
  input  logic [REALM_W-1:0]  beat_realm,
  input  logic [N_REALMS-1:0] user_bits,
  input  logic [N_REALMS-1:0] group_bits,
  input  logic                super_hit,
  output logic                busy,
  output logic                resp_valid,
  output logic                resp_allow
);
  logic [N_REALMS-1:0] acc_q;
  logic [N_REALMS-1:0] cur_bits;
  logic                finish;
  logic                realm_hit;

  always_comb begin
    if (!busy) begin
      if (!beat_group) begin
        cur_bits = super_hit ? '1 : user_bits;
        finish   = beat;
      end else begin
        cur_bits = group_bits;
        finish   = beat && beat_last;
      end
    end else begin
      cur_bits = acc_q | group_bits;
      finish   = beat && beat_last;
    end
  end

  // realm numbers beyond the defined bits never match
  always_comb begin
    realm_hit = 1'b0;
    for (int r = 0; r < N_REALMS; r++) begin
      if (beat_realm == REALM_W'(r)) realm_hit = cur_bits[r];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      acc_q      <= '0;
      resp_valid <= 1'b0;
      resp_allow <= 1'b0;
    end else begin
      resp_valid <= finish;
      resp_allow <= finish && realm_hit;
      if (beat) begin
        if (finish) begin
          busy  <= 1'b0;
          acc_q <= '0;
        end else begin
          busy  <= 1'b1;
          acc_q <= cur_bits;
        end
      end
    end
  end
endmodule

// File: rtl/realm_permission_checker.sv
module realm_permission_checker #(
  parameter int              N_USER    = 8,
  parameter int              N_GROUP   = 8,
  parameter int              KEY_W     = 8,
  parameter int              REALM_W   = 4,
  parameter int              N_REALMS  = 12,
  parameter int              SEC_REALM = 11,
  parameter logic [KEY_W-1:0] SUPER_KEY = 8'hFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                q_valid,
  output logic                q_ready,
  input  logic                q_group,
  input  logic                q_last,
  input  logic [KEY_W-1:0]    q_key,
  input  logic [REALM_W-1:0]  q_realm,
  output logic                resp_valid,
  output logic                resp_allow,
  input  logic                cfg_valid,
  output logic                cfg_ready,
  input  logic [KEY_W-1:0]    cfg_caller,
  input  logic                cfg_group,
  input  logic                cfg_clear,
  input  logic [$clog2((N_USER > N_GROUP) ? N_USER : N_GROUP)-1:0] cfg_index,
  input  logic [KEY_W-1:0]    cfg_key,
  input  logic [N_REALMS-1:0] cfg_bits
);
  import realm_chk_pkg::*;

  localparam int IDX_W = $clog2((N_USER > N_GROUP) ? N_USER : N_GROUP);

  logic                        grp_busy;
  logic [1:0][KEY_W-1:0]       user_lk_key;
  logic [1:0][N_REALMS-1:0]    user_lk_bits;
  logic [0:0][KEY_W-1:0]       grp_lk_key;
  logic [0:0][N_REALMS-1:0]    grp_lk_bits;
  logic                        caller_ok;
  logic                        cfg_fire;
  tbl_sel_e                    cfg_tbl;

  assign q_ready   = 1'b1;
  assign cfg_ready = !q_valid && !grp_busy;
  assign cfg_tbl   = tbl_sel_e'(cfg_group);

  assign user_lk_key[0] = q_key;
  assign user_lk_key[1] = cfg_caller;
  assign grp_lk_key[0]  = q_key;

  assign caller_ok = (cfg_caller == SUPER_KEY) || user_lk_bits[1][SEC_REALM];
  assign cfg_fire  = cfg_valid && cfg_ready && caller_ok;

  realm_table #(
    .N(N_USER), .KEY_W(KEY_W), .N_REALMS(N_REALMS), .IDX_W(IDX_W), .NLK(2)
  ) i_user_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_fire && (cfg_tbl == TBL_USER)),
    .wr_clear (cfg_clear),
    .wr_idx   (cfg_index),
    .wr_key   (cfg_key),
    .wr_bits  (cfg_bits),
    .lk_key   (user_lk_key),
    .lk_bits  (user_lk_bits)
  );

  realm_table #(
    .N(N_GROUP), .KEY_W(KEY_W), .N_REALMS(N_REALMS), .IDX_W(IDX_W), .NLK(1)
  ) i_group_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_fire && (cfg_tbl == TBL_GROUP)),
    .wr_clear (cfg_clear),
    .wr_idx   (cfg_index),
    .wr_key   (cfg_key),
    .wr_bits  (cfg_bits),
    .lk_key   (grp_lk_key),
    .lk_bits  (grp_lk_bits)
  );

  realm_accum #(
    .N_REALMS(N_REALMS), .REALM_W(REALM_W)
  ) i_accum (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat       (q_valid && q_ready),
    .beat_group (q_group),
    .beat_last  (q_last),
    .beat_realm (q_realm),
    .user_bits  (user_lk_bits[0]),
    .group_bits (grp_lk_bits[0]),
    .super_hit  (q_key == SUPER_KEY),
    .busy       (grp_busy),
    .resp_valid (resp_valid),
    .resp_allow (resp_allow)
  );
endmodule

// File: rtl/realm_permission_checker_chk.sv
module realm_permission_checker_chk #(
  parameter int               KEY_W     = 8,
  parameter int               REALM_W   = 4,
  parameter int               N_REALMS  = 12,
  parameter logic [KEY_W-1:0] SUPER_KEY = 8'hFF
) (
  input logic               clk,
  input logic               rst_n,
  input logic               q_valid,
  input logic               q_ready,
  input logic               q_group,
  input logic               q_last,
  input logic [KEY_W-1:0]   q_key,
  input logic [REALM_W-1:0] q_realm,
  input logic               resp_valid,
  input logic               resp_allow,
  input logic               cfg_ready,
  input logic               grp_busy
);
  assert_allow_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_allow |-> resp_valid);

  assert_last_gives_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && q_last) |=> resp_valid);

  assert_resp_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $past(q_valid));

  assert_undef_realm_deny_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && q_last && (q_realm >= REALM_W'(N_REALMS))) |=> !resp_allow);

  assert_super_allow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !grp_busy && !q_group && (q_key == SUPER_KEY) &&
     (q_realm < REALM_W'(N_REALMS))) |=> resp_allow);

  assert_user_single_beat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !grp_busy && !q_group) |=> (resp_valid && !grp_busy));

  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid || grp_busy) |-> !cfg_ready);

  assert_qready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    q_ready);
endmodule

bind realm_permission_checker realm_permission_checker_chk #(
  .KEY_W(KEY_W), .REALM_W(REALM_W), .N_REALMS(N_REALMS), .SUPER_KEY(SUPER_KEY)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .q_valid    (q_valid),
  .q_ready    (q_ready),
  .q_group    (q_group),
  .q_last     (q_last),
  .q_key      (q_key),
  .q_realm    (q_realm),
  .resp_valid (resp_valid),
  .resp_allow (resp_allow),
  .cfg_ready  (cfg_ready),
  .grp_busy   (grp_busy)
);

// File: tb/test_realm_permission_checker.sv
module test_realm_permission_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        q_valid = 1'b0, q_group = 1'b0, q_last = 1'b0;
  logic [7:0]  q_key = '0;
  logic [3:0]  q_realm = '0;
  logic        q_ready, resp_valid, resp_allow, cfg_ready;
  logic        cfg_valid = 1'b0, cfg_group = 1'b0, cfg_clear = 1'b0;
  logic [7:0]  cfg_caller = '0, cfg_key = '0;
  logic [2:0]  cfg_index = '0;
  logic [11:0] cfg_bits = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of the tables
  logic        mu_v [8];
  logic [7:0]  mu_k [8];
  logic [11:0] mu_b [8];
  logic        mg_v [8];
  logic [7:0]  mg_k [8];
  logic [11:0] mg_b [8];

  always #2 clk = ~clk;

  realm_permission_checker i_realm_permission_checker (
    .clk(clk), .rst_n(rst_n),
    .q_valid(q_valid), .q_ready(q_ready), .q_group(q_group), .q_last(q_last),
    .q_key(q_key), .q_realm(q_realm),
    .resp_valid(resp_valid), .resp_allow(resp_allow),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_caller(cfg_caller),
    .cfg_group(cfg_group), .cfg_clear(cfg_clear), .cfg_index(cfg_index),
    .cfg_key(cfg_key), .cfg_bits(cfg_bits)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] user_rights(input logic [7:0] key);
    logic [11:0] r = '0;
    for (int i = 0; i < 8; i++) if (mu_v[i] && mu_k[i] == key) r |= mu_b[i];
    return r;
  endfunction

  function automatic logic [11:0] group_rights(input logic [7:0] key);
    logic [11:0] r = '0;
    for (int i = 0; i < 8; i++) if (mg_v[i] && mg_k[i] == key) r |= mg_b[i];
    return r;
  endfunction

  function automatic logic realm_ok(input logic [11:0] rights, input int realm);
    return (realm < 12) ? rights[realm] : 1'b0;
  endfunction

  task automatic cfg_beat(input logic [7:0] caller, input logic grp, input logic clr,
                          input int idx, input logic [7:0] key, input logic [11:0] bits);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_caller = caller; cfg_group = grp; cfg_clear = clr;
    cfg_index = 3'(idx); cfg_key = key; cfg_bits = bits;
    @(negedge clk);
    cfg_valid = 1'b0;
    if (caller == 8'hFF || user_rights(caller)[11]) begin
      if (!grp) begin
        if (clr) mu_v[idx] = 1'b0;
        else begin mu_v[idx] = 1'b1; mu_k[idx] = key; mu_b[idx] = bits; end
      end else begin
        if (clr) mg_v[idx] = 1'b0;
        else begin mg_v[idx] = 1'b1; mg_k[idx] = key; mg_b[idx] = bits; end
      end
    end
  endtask

  task automatic q_user(input logic [7:0] key, input int realm, input logic lastf, input string tag);
    logic [11:0] rights;
    rights = (key == 8'hFF) ? 12'hFFF : user_rights(key);
    @(negedge clk);
    q_valid = 1'b1; q_group = 1'b0; q_last = lastf; q_key = key; q_realm = 4'(realm);
    @(negedge clk);
    chk({tag, " R7 strobe"}, resp_valid, 1'b1);
    chk(tag, resp_allow, realm_ok(rights, realm));
    q_valid = 1'b0;
  endtask

  task automatic q_grp(input logic [7:0] ids [4], input int n, input int realm,
                       input bit gap, input string tag);
    logic [11:0] rights = '0;
    for (int k = 0; k < n; k++) rights |= group_rights(ids[k]);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      q_valid = 1'b1; q_group = 1'b1; q_key = ids[k];
      q_last = (k == n - 1);
      q_realm = (k == n - 1) ? 4'(realm) : 4'(15 - realm);
      if (gap && k < n - 1) begin
        @(negedge clk);
        q_valid = 1'b0;
        #1;
        chk("R10 cfg_ready low in open stream", cfg_ready, 1'b0);
        chk("R7 no strobe mid-stream", resp_valid, 1'b0);
      end
    end
    @(negedge clk);
    chk({tag, " R7 strobe"}, resp_valid, 1'b1);
    chk(tag, resp_allow, realm_ok(rights, realm));
    q_valid = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] ids [4];
    for (int i = 0; i < 8; i++) begin
      mu_v[i] = 0; mu_k[i] = 0; mu_b[i] = 0; mg_v[i] = 0; mg_k[i] = 0; mg_b[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 resp_valid after reset", resp_valid, 1'b0);
    chk("R1 resp_allow after reset", resp_allow, 1'b0);
    chk("R1 cfg_ready after reset", cfg_ready, 1'b1);
    chk("R10 q_ready", q_ready, 1'b1);
    q_user(8'h00, 0, 1'b1, "R1 R3 empty table deny");

    // R4 R5: super key over all realms
    for (int r = 0; r < 16; r++) q_user(8'hFF, r, 1'b1, "R4 R5 super sweep");

    // R9: writes by super
    cfg_beat(8'hFF, 1'b0, 1'b0, 0, 8'd5, 12'h0A5);
    cfg_beat(8'hFF, 1'b0, 1'b0, 1, 8'd6, 12'h803);
    cfg_beat(8'hFF, 1'b0, 1'b0, 2, 8'd5, 12'h300);
    for (int r = 0; r < 16; r++) begin
      q_user(8'd5, r, 1'b1, "R2 duplicate key OR");
      q_user(8'd6, r, 1'b1, "R2 R5 user sweep");
    end

    // R8: caller without security realm is ignored, caller with it is obeyed
    cfg_beat(8'd5, 1'b0, 1'b0, 3, 8'd7, 12'hFFF);
    for (int r = 0; r < 16; r++) q_user(8'd7, r, 1'b1, "R8 unauthorised write ignored");
    cfg_beat(8'd5, 1'b1, 1'b0, 4, 8'd70, 12'hFFF);
    ids = '{8'd70, 8'd0, 8'd0, 8'd0};
    q_grp(ids, 1, 3, 1'b0, "R8 unauthorised group write ignored");
    cfg_beat(8'd6, 1'b0, 1'b0, 3, 8'd7, 12'h0F0);
    for (int r = 0; r < 16; r++) q_user(8'd7, r, 1'b1, "R8 authorised write");

    // R9 clear
    cfg_beat(8'hFF, 1'b0, 1'b1, 2, 8'd0, 12'h000);
    for (int r = 0; r < 16; r++) q_user(8'd5, r, 1'b1, "R9 cleared slot");

    // R11: user beat without last marker still completes
    q_user(8'd6, 11, 1'b0, "R11 user beat ignores last");
    q_user(8'd6, 2, 1'b0, "R11 user beat ignores last");

    // fill remaining user slots
    for (int i = 4; i < 8; i++) cfg_beat(8'd6, 1'b0, 1'b0, i, 8'(40 + i), 12'(1 << i) | 12'h001);
    cfg_beat(8'hFF, 1'b0, 1'b0, 2, 8'd44, 12'h400);

    // groups
    cfg_beat(8'hFF, 1'b1, 1'b0, 0, 8'd10, 12'h00F);
    cfg_beat(8'hFF, 1'b1, 1'b0, 1, 8'd20, 12'h0F0);
    cfg_beat(8'hFF, 1'b1, 1'b0, 7, 8'd30, 12'hF00);
    cfg_beat(8'hFF, 1'b1, 1'b0, 5, 8'd20, 12'h100);
    for (int r = 0; r < 16; r++) begin
      ids = '{8'd10, 8'd0, 8'd0, 8'd0};
      q_grp(ids, 1, r, 1'b0, "R6 single group");
      ids = '{8'd10, 8'd20, 8'd0, 8'd0};
      q_grp(ids, 2, r, 1'b0, "R6 two groups OR");
      ids = '{8'd30, 8'd99, 8'd10, 8'd20};
      q_grp(ids, 4, r, 1'b1, "R6 stream with gaps");
      ids = '{8'd99, 8'd5, 8'd0, 8'd0};
      q_grp(ids, 2, r, 1'b0, "R3 no group match");
    end
    cfg_beat(8'hFF, 1'b1, 1'b1, 1, 8'd0, 12'h000);
    for (int r = 0; r < 16; r++) begin
      ids = '{8'd10, 8'd20, 8'd0, 8'd0};
      q_grp(ids, 2, r, 1'b0, "R9 group slot cleared");
    end

    // near-exhaustive user sweep over keys and realms
    for (int key = 0; key < 256; key++)
      for (int r = 0; r < 16; r++) q_user(8'(key), r, 1'b1, "R2 R3 R4 R5 full sweep");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule